// File: doc/BRIEF.md
# Byte/Word Arithmetic-Logic Unit with Status Flags

This unit is the arithmetic and logic stage of an execution core. For each accepted operation it works on two operands at byte or word size. It registers the result and updates a packed flag word that holds six condition bits and three control bits. The operations are addition, subtraction, the three bitwise logic functions, increment, decrement, one's complement and single-position shifts. Each operation affects the condition bits according to its own rule.

A separate command strobe sets, clears or inverts one flag in a single cycle. This is how the core changes the carry, direction, interrupt-enable and trap bits outside of arithmetic. When an operation and a command arrive in the same cycle, the operation updates the condition bits first and the command then acts on that new value. Decoding of instructions, multiply, divide and rotates through carry belong to other stages.

Top module: `alu_flags_unit`

## Requirements
- R1: While `rst_n` is low, `result` and `flags` are all zero.
- R2: Operation codes: 0 add, 1 subtract (a-b), 2 AND, 3 OR, 4 XOR, 5 increment a, 6 decrement a, 7 one's complement of a, 8 shift a left by one, 9 logical shift a right by one, 10 arithmetic shift a right by one. The size is 8 bits when `size_word`=0 and 16 bits when it is 1. After a clock edge with `op_valid` high, `result` holds the value reduced modulo 2^size, and bits 15:8 are zero for byte operations.
- R3: Carry (bit 0) takes the carry out of an add, or the borrow of a subtract (a<b unsigned). For the shifts it takes the bit shifted out. AND, OR and XOR clear it, and increment and decrement leave it unchanged.
- R4: Auxiliary carry (bit 4) is set on a carry or borrow from bit 3 into bit 4 for add, subtract, increment and decrement. AND, OR and XOR clear it, and the shifts leave it unchanged.
- R5: Every operation except complement updates three flags. Parity (bit 2) is 1 when result bits 7:0 hold an even count of ones, also at word size. Zero (bit 6) is 1 when the sized result is zero. Sign (bit 7) copies the top bit of the sized result.
- R6: Overflow (bit 11) flags signed overflow for add, subtract, increment and decrement. For a left shift it is the result's top bit XOR carry. For a logical right shift it is the operand's top bit. An arithmetic right shift and the logic operations clear it.
- R7: Complement leaves all flags unchanged.
- R8: The flag word holds carry 0, parity 2, auxiliary 4, zero 6, sign 7, trap 8, interrupt-enable 9, direction 10 and overflow 11. All other bits read zero.
- R9: On a clock edge with `fcmd_valid` high, `fcmd_code` acts on one flag and no other: 0 clear carry, 1 invert carry, 2 set carry, 3 clear direction, 4 set direction, 5 clear interrupt-enable, 6 set interrupt-enable, 7 clear trap, 8 set trap. Codes 9 to 15 change nothing.
- R10: When an operation and a command are accepted in the same cycle, the command acts on the flag value that the operation produced.
- R11: Operation codes 11 to 15, and cycles with neither strobe, leave `result` and `flags` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Accept an operation this cycle |
| op_code | input | 4 | Operation select (R2 codes) |
| size_word | input | 1 | 1 selects 16-bit, 0 selects 8-bit operands |
| opnd_a | input | 16 | First operand |
| opnd_b | input | 16 | Second operand |
| fcmd_valid | input | 1 | Accept a flag command this cycle |
| fcmd_code | input | 4 | Flag command select (R9 codes) |
| result | output | 16 | Registered result of the last accepted operation |
| flags | output | 16 | Registered flag word |

## Verification
The embedded assertions watch several rules on every cycle. Complement keeps the flag word intact, and increment and decrement keep carry. The logic operations clear carry, auxiliary carry and overflow. Idle cycles hold both outputs, byte results have a zero upper half, setting direction takes effect, and the unused flag bits stay zero.

The arithmetic correctness of each condition bit can only be shown by the bench's sweeps against a model written with integer arithmetic. That covers the carry, borrow, nibble carry, signed overflow, parity and shifted-out bit. The bench also covers the ordering when an operation and a command share a cycle, and the no-effect codes.

// File: rtl/alu_flags_pkg.sv
package alu_flags_pkg;

   localparam logic [3:0] OP_ADD = 4'd0;
   localparam logic [3:0] OP_SUB = 4'd1;
   localparam logic [3:0] OP_AND = 4'd2;
   localparam logic [3:0] OP_OR  = 4'd3;
   localparam logic [3:0] OP_XOR = 4'd4;
   localparam logic [3:0] OP_INC = 4'd5;
   localparam logic [3:0] OP_DEC = 4'd6;
   localparam logic [3:0] OP_NOT = 4'd7;
   localparam logic [3:0] OP_SHL = 4'd8;
   localparam logic [3:0] OP_SHR = 4'd9;
   localparam logic [3:0] OP_SAR = 4'd10;
   localparam logic [3:0] OP_LAST = OP_SAR;

   localparam logic [3:0] FC_CARRY_CLR = 4'd0;
   localparam logic [3:0] FC_CARRY_INV = 4'd1;
   localparam logic [3:0] FC_CARRY_SET = 4'd2;
   localparam logic [3:0] FC_DIR_CLR   = 4'd3;
   localparam logic [3:0] FC_DIR_SET   = 4'd4;
   localparam logic [3:0] FC_INTE_CLR  = 4'd5;
   localparam logic [3:0] FC_INTE_SET  = 4'd6;
   localparam logic [3:0] FC_TRAP_CLR  = 4'd7;
   localparam logic [3:0] FC_TRAP_SET  = 4'd8;

   localparam int FLAG_W = 16;
   localparam int FB_CARRY = 0;
   localparam int FB_PAR   = 2;
   localparam int FB_AUX   = 4;
   localparam int FB_ZERO  = 6;
   localparam int FB_SIGN  = 7;
   localparam int FB_TRAP  = 8;
   localparam int FB_INTE  = 9;
   localparam int FB_DIR   = 10;
   localparam int FB_OVF   = 11;

   localparam logic [FLAG_W-1:0] FLAG_USED_MASK = 16'h0FD5;

   localparam int PAR_W   = 8;
   localparam int AUX_BIT = 4;

endpackage

// File: rtl/alu_core_dp.sv
module alu_core_dp
   import alu_flags_pkg::*;
#(
   parameter int WORD_W = 16,
   parameter int BYTE_W = 8
) (
   input  logic [3:0]        op,
   input  logic              size_word,
   input  logic [WORD_W-1:0] a,
   input  logic [WORD_W-1:0] b,
   output logic [WORD_W-1:0] res,
   output logic              co,
   output logic              ao,
   output logic              vo,
   output logic              legal
);

   logic [WORD_W-1:0] mask;
   logic [WORD_W-1:0] am;
   logic [WORD_W-1:0] bm;
   logic [WORD_W-1:0] opb;
   logic [WORD_W:0]   wide;
   logic              is_sub;
   int unsigned       ms;

   always_comb begin
      mask = '0;
      mask[BYTE_W-1:0] = '1;
      if (size_word) mask = '1;
      ms = size_word ? WORD_W-1 : BYTE_W-1;
      am = opnd_mask(a, mask);
      bm = opnd_mask(b, mask);
      opb = ((op == OP_INC) || (op == OP_DEC)) ? WORD_W'(1) : bm;
      is_sub = (op == OP_SUB) || (op == OP_DEC);
      wide = is_sub ? ({1'b0, am} - {1'b0, opb}) : ({1'b0, am} + {1'b0, opb});

      res   = '0;
      co    = 1'b0;
      ao    = 1'b0;
      vo    = 1'b0;
      legal = 1'b1;
      case (op)
         OP_ADD, OP_SUB, OP_INC, OP_DEC: begin
            res = wide[WORD_W-1:0] & mask;
            co  = size_word ? wide[WORD_W] : wide[BYTE_W];
            ao  = am[AUX_BIT] ^ opb[AUX_BIT] ^ res[AUX_BIT];
            if (is_sub)
               vo = (am[ms] != opb[ms]) && (res[ms] != am[ms]);
            else
               vo = (am[ms] == opb[ms]) && (res[ms] != am[ms]);
         end
         OP_AND: res = am & bm;
         OP_OR:  res = am | bm;
         OP_XOR: res = am ^ bm;
         OP_NOT: res = ~am & mask;
         OP_SHL: begin
            res = (am << 1) & mask;
            co  = am[ms];
            vo  = res[ms] ^ am[ms];
         end
         OP_SHR: begin
            res = am >> 1;
            co  = am[0];
            vo  = am[ms];
         end
         OP_SAR: begin
            res     = am >> 1;
            res[ms] = am[ms];
            co      = am[0];
         end
         default: legal = 1'b0;
      endcase
   end

   function automatic logic [WORD_W-1:0] opnd_mask(input logic [WORD_W-1:0] v,
                                                   input logic [WORD_W-1:0] m);
      return v & m;
   endfunction

endmodule

// File: rtl/alu_flag_eval.sv
module alu_flag_eval
   import alu_flags_pkg::*;
#(
   parameter int WORD_W = 16,
   parameter int BYTE_W = 8
) (
   input  logic [3:0]        op,
   input  logic              size_word,
   input  logic [WORD_W-1:0] res,
   input  logic              co,
   input  logic              ao,
   input  logic              vo,
   input  logic [FLAG_W-1:0] flags_in,
   output logic [FLAG_W-1:0] flags_out
);

   logic [PAR_W:0] par_chain;
   logic           even_par;
   logic           zf;
   logic           sf;

   assign par_chain[0] = 1'b0;
   for (genvar i = 0; i < PAR_W; i++) begin : g_par
      assign par_chain[i+1] = par_chain[i] ^ res[i];
   end
   assign even_par = ~par_chain[PAR_W];
   assign zf = (res == '0);
   assign sf = size_word ? res[WORD_W-1] : res[BYTE_W-1];

   always_comb begin
      flags_out = flags_in;
      case (op)
         OP_ADD, OP_SUB, OP_INC, OP_DEC: begin
            if ((op == OP_ADD) || (op == OP_SUB)) flags_out[FB_CARRY] = co;
            flags_out[FB_AUX]  = ao;
            flags_out[FB_OVF]  = vo;
            flags_out[FB_PAR]  = even_par;
            flags_out[FB_ZERO] = zf;
            flags_out[FB_SIGN] = sf;
         end
         OP_AND, OP_OR, OP_XOR: begin
            flags_out[FB_CARRY] = 1'b0;
            flags_out[FB_AUX]   = 1'b0;
            flags_out[FB_OVF]   = 1'b0;
            flags_out[FB_PAR]   = even_par;
            flags_out[FB_ZERO]  = zf;
            flags_out[FB_SIGN]  = sf;
         end
         OP_SHL, OP_SHR, OP_SAR: begin
            flags_out[FB_CARRY] = co;
            flags_out[FB_OVF]   = vo;
            flags_out[FB_PAR]   = even_par;
            flags_out[FB_ZERO]  = zf;
            flags_out[FB_SIGN]  = sf;
         end
         default: ;
      endcase
   end

endmodule

// File: rtl/alu_flags_unit.sv
module alu_flags_unit
   import alu_flags_pkg::*;
#(
   parameter int WORD_W = 16,
   parameter int BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              op_valid,
   input  logic [3:0]        op_code,
   input  logic              size_word,
   input  logic [WORD_W-1:0] opnd_a,
   input  logic [WORD_W-1:0] opnd_b,
   input  logic              fcmd_valid,
   input  logic [3:0]        fcmd_code,
   output logic [WORD_W-1:0] result,
   output logic [15:0]       flags
);

   if (BYTE_W < PAR_W) begin : g_bad_byte
      $error("BYTE_W must cover the parity byte");
   end
   if (WORD_W <= BYTE_W) begin : g_bad_word
      $error("WORD_W must exceed BYTE_W");
   end

   logic [WORD_W-1:0] dp_res;
   logic              dp_co;
   logic              dp_ao;
   logic              dp_vo;
   logic              dp_legal;
   logic [FLAG_W-1:0] eval_flags;
   logic [FLAG_W-1:0] flg_q;
   logic [FLAG_W-1:0] flg_nxt;
   logic [WORD_W-1:0] res_q;

   alu_core_dp #(.WORD_W(WORD_W), .BYTE_W(BYTE_W)) u_dp (
      .op        (op_code),
      .size_word (size_word),
      .a         (opnd_a),
      .b         (opnd_b),
      .res       (dp_res),
      .co        (dp_co),
      .ao        (dp_ao),
      .vo        (dp_vo),
      .legal     (dp_legal)
   );

   alu_flag_eval #(.WORD_W(WORD_W), .BYTE_W(BYTE_W)) u_eval (
      .op        (op_code),
      .size_word (size_word),
      .res       (dp_res),
      .co        (dp_co),
      .ao        (dp_ao),
      .vo        (dp_vo),
      .flags_in  (flg_q),
      .flags_out (eval_flags)
   );

   always_comb begin
      flg_nxt = flg_q;
      if (op_valid && dp_legal) flg_nxt = eval_flags;
      if (fcmd_valid) begin
         case (fcmd_code)
            FC_CARRY_CLR: flg_nxt[FB_CARRY] = 1'b0;
            FC_CARRY_INV: flg_nxt[FB_CARRY] = ~flg_nxt[FB_CARRY];
            FC_CARRY_SET: flg_nxt[FB_CARRY] = 1'b1;
            FC_DIR_CLR:   flg_nxt[FB_DIR]   = 1'b0;
            FC_DIR_SET:   flg_nxt[FB_DIR]   = 1'b1;
            FC_INTE_CLR:  flg_nxt[FB_INTE]  = 1'b0;
            FC_INTE_SET:  flg_nxt[FB_INTE]  = 1'b1;
            FC_TRAP_CLR:  flg_nxt[FB_TRAP]  = 1'b0;
            FC_TRAP_SET:  flg_nxt[FB_TRAP]  = 1'b1;
            default: ;
         endcase
      end
      flg_nxt = flg_nxt & FLAG_USED_MASK;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         flg_q <= '0;
         res_q <= '0;
      end else begin
         flg_q <= flg_nxt;
         if (op_valid && dp_legal) res_q <= dp_res;
      end
   end

   assign result = res_q;
   assign flags  = flg_q;

   AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (flags & ~FLAG_USED_MASK) == '0); // R8
   AST_COMPLEMENT_KEEPS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_code == OP_NOT && !fcmd_valid) |=> $stable(flags)); // R7
   AST_INCDEC_KEEPS_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && (op_code == OP_INC || op_code == OP_DEC) && !fcmd_valid)
      |=> flags[FB_CARRY] == $past(flags[FB_CARRY])); // R3
   AST_LOGIC_CLEARS_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && (op_code == OP_AND || op_code == OP_OR || op_code == OP_XOR) && !fcmd_valid)
      |=> !flags[FB_CARRY] && !flags[FB_AUX] && !flags[FB_OVF]); // R4
   AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (!op_valid && !fcmd_valid) |=> $stable(flags) && $stable(result)); // R11
   AST_DIR_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (fcmd_valid && fcmd_code == FC_DIR_SET) |=> flags[FB_DIR]); // R9
   AST_BYTE_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && !size_word && op_code <= OP_LAST) |=> result[WORD_W-1:BYTE_W] == '0); // R2

endmodule

// File: tb/tb_alu_flags_unit.sv
module tb_alu_flags_unit;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        op_valid;
   logic [3:0]  op_code;
   logic        size_word;
   logic [15:0] opnd_a;
   logic [15:0] opnd_b;
   logic        fcmd_valid;
   logic [3:0]  fcmd_code;
   logic [15:0] result;
   logic [15:0] flags;

   int          n_vec = 0;
   int          n_bad = 0;
   logic [15:0] exp_res;
   logic [15:0] exp_flg;
   logic [15:0] lf = 16'hACE1;

   always #(CLK_PERIOD/2) clk = ~clk;

   alu_flags_unit dut (
      .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
      .size_word(size_word), .opnd_a(opnd_a), .opnd_b(opnd_b),
      .fcmd_valid(fcmd_valid), .fcmd_code(fcmd_code),
      .result(result), .flags(flags)
   );

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
   endtask

   task automatic check(input string tag);
      n_vec++;
      if (result !== exp_res || flags !== exp_flg) begin
         n_bad++;
         $display("FAIL %s: result=%h flags=%h expected result=%h flags=%h",
                  tag, result, flags, exp_res, exp_flg);
      end
   endtask

   task automatic model_cmd(input logic [3:0] cc);
      case (cc)
         4'd0: exp_flg[0]  = 1'b0;
         4'd1: exp_flg[0]  = ~exp_flg[0];
         4'd2: exp_flg[0]  = 1'b1;
         4'd3: exp_flg[10] = 1'b0;
         4'd4: exp_flg[10] = 1'b1;
         4'd5: exp_flg[9]  = 1'b0;
         4'd6: exp_flg[9]  = 1'b1;
         4'd7: exp_flg[8]  = 1'b0;
         4'd8: exp_flg[8]  = 1'b1;
         default: ;
      endcase
   endtask

   task automatic model_op(input int op, input bit sz, input int ai, input int bi);
      int md = sz ? 65536 : 256;
      int hm = md / 2;
      int a = ai % md;
      int b = bi % md;
      int r, sa, sb, s, ones;
      bit c, af, v;
      bit upd_c, upd_a, upd_v, upd_pzs;
      c = exp_flg[0]; af = exp_flg[4]; v = exp_flg[11];
      upd_c = 0; upd_a = 0; upd_v = 0; upd_pzs = 1;
      if (op > 10) return;
      if (op == 5 || op == 6) b = 1;
      sa = (a >= hm) ? a - md : a;
      sb = (b >= hm) ? b - md : b;
      case (op)
         0, 5: begin
            r = a + b; c = r >= md; r = r % md;
            af = ((a % 16) + (b % 16)) > 15;
            s = sa + sb; v = (s < -hm) || (s >= hm);
            upd_c = (op == 0); upd_a = 1; upd_v = 1;
         end
         1, 6: begin
            r = (a - b + md) % md; c = a < b;
            af = (a % 16) < (b % 16);
            s = sa - sb; v = (s < -hm) || (s >= hm);
            upd_c = (op == 1); upd_a = 1; upd_v = 1;
         end
         2: begin r = a & b; c = 0; af = 0; v = 0; upd_c = 1; upd_a = 1; upd_v = 1; end
         3: begin r = a | b; c = 0; af = 0; v = 0; upd_c = 1; upd_a = 1; upd_v = 1; end
         4: begin r = a ^ b; c = 0; af = 0; v = 0; upd_c = 1; upd_a = 1; upd_v = 1; end
         7: begin r = (md - 1) - a; upd_pzs = 0; end
         8: begin
            r = (a * 2) % md; c = a >= hm; v = (r >= hm) != c;
            upd_c = 1; upd_v = 1;
         end
         9: begin r = a / 2; c = a % 2; v = a >= hm; upd_c = 1; upd_v = 1; end
         default: begin
            r = a / 2 + ((a >= hm) ? hm : 0); c = a % 2; v = 0;
            upd_c = 1; upd_v = 1;
         end
      endcase
      exp_res = 16'(r);
      if (upd_c) exp_flg[0] = c;
      if (upd_a) exp_flg[4] = af;
      if (upd_v) exp_flg[11] = v;
      if (upd_pzs) begin
         ones = 0;
         for (int i = 0; i < 8; i++) ones += (r >> i) & 1;
         exp_flg[2] = (ones % 2) == 0;
         exp_flg[6] = (r == 0);
         exp_flg[7] = (r >= hm);
      end
   endtask

   task automatic vec(input bit ov, input int op, input bit sz, input int a, input int b,
                      input bit cv, input int cc, input string tag);
      op_valid   = ov;
      op_code    = 4'(op);
      size_word  = sz;
      opnd_a     = 16'(a);
      opnd_b     = 16'(b);
      fcmd_valid = cv;
      fcmd_code  = 4'(cc);
      @(negedge clk);
      if (ov) model_op(op, sz, a, b);
      if (cv) model_cmd(4'(cc));
      check(tag);
      op_valid   = 1'b0;
      fcmd_valid = 1'b0;
   endtask

   task automatic lf_step();
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      summary();
      $finish;
   end

   initial begin
      rst_n = 1'b0; op_valid = 1'b0; op_code = '0; size_word = 1'b0;
      opnd_a = '0; opnd_b = '0; fcmd_valid = 1'b0; fcmd_code = '0;
      exp_res = '0; exp_flg = '0;
      repeat (3) @(negedge clk);
      check("R1 reset state");
      rst_n = 1'b1;

      // corner values
      vec(1, 0, 0, 255, 1,   0, 0, "R3 byte carry 255+1");
      vec(1, 0, 0, 100, 50,  0, 0, "R6 byte overflow 100+50");
      vec(1, 0, 1, 16'hFFFF, 1, 0, 0, "R3 R5 word wrap to zero");
      vec(1, 0, 1, 16'h7FFF, 1, 0, 0, "R6 word signed overflow");
      vec(1, 1, 0, 0, 1,     0, 0, "R3 R4 byte borrow");
      vec(1, 6, 1, 16'h8000, 0, 0, 0, "R6 word decrement overflow");
      vec(1, 0, 1, 16'h0100, 16'h0000, 0, 0, "R5 parity on low byte only");

      // byte add/sub sweep
      for (int a = 0; a < 256; a++)
         for (int b = 0; b < 256; b += 5) begin
            vec(1, 0, 0, a, b, 0, 0, "R2 R3 R4 R5 R6 byte add");
            vec(1, 1, 0, a, b, 0, 0, "R2 R3 R4 R5 R6 byte sub");
         end

      // byte other ops, full operand-a sweep; upper input bits set to prove masking
      for (int op = 2; op <= 10; op++)
         for (int a = 0; a < 256; a++)
            vec(1, op, 0, a + 16'hA500, (a * 73 + 11) % 256 + 16'h5A00, 0, 0,
                "R2 R3 R4 R5 R6 R7 byte op");

      // word sweep for every operation
      for (int op = 0; op <= 10; op++)
         for (int k = 0; k < 1500; k++) begin
            int a = lf;
            lf_step();
            vec(1, op, 1, a, lf, 0, 0, "R2 R3 R4 R5 R6 R7 word op");
            lf_step();
         end

      // flag commands alone
      for (int k = 0; k < 48; k++)
         vec(0, 0, 0, 0, 0, 1, (k * 7 + 3) % 16, "R8 R9 flag command");

      // operation and command together
      vec(1, 0, 0, 255, 1, 1, 1, "R10 add then invert carry");
      vec(1, 1, 0, 3, 5,   1, 0, "R10 sub then clear carry");
      vec(1, 8, 1, 16'h8001, 0, 1, 4, "R10 shift with direction set");
      vec(1, 7, 1, 16'h1234, 0, 1, 8, "R7 R10 complement with trap set");

      // undefined codes and idle cycles
      for (int op = 11; op <= 15; op++)
         vec(1, op, op % 2, 16'hFFFF, 16'h1111, 0, 0, "R11 undefined code");
      for (int k = 0; k < 4; k++)
         vec(0, 0, 1, 16'hFFFF, 16'hFFFF, 0, 0, "R11 idle cycle");

      summary();
      $finish;
   end

endmodule